// File: doc/BRIEF.md
# Loop Replay Qualifier

This block watches the micro-op stream as it is written into the micro-op queue and decides whether the code being executed is a short loop that the queue can replay on its own. A loop is identified by a taken backward branch; the target of the first such branch becomes the loop head. Each later taken backward branch to the same head closes one iteration. Every closed iteration is judged against a set of limits: micro-op count, taken-branch count, micro-op source, absence of calls and returns, and push/pop balance.

Once enough consecutive iterations pass (two by default), the block raises a replay signal. This signal tells the queue to stream the captured loop and tells the front end to sleep. It also reports the queue indices of the first and last micro-op of the loop body. A branch misprediction, a pipeline flush or a thread switch drops replay and discards all progress. The queue storage, the branch predictor and the micro-op cache sit outside this block.

Top module: `lsd_qualifier`

## Requirements
- R1: Replay rises in the cycle after the second consecutive qualifying iteration closes. An iteration closes on a taken backward branch (uop_taken=1, uop_backward=1) whose uop_target equals the recorded head. loop_start_idx is then the index of the micro-op after the previous closing branch, and loop_end_idx is the index of the closing branch. After only one qualifying iteration, replay stays low.
- R2: An iteration of at most 28 micro-ops, counting the closing branch, qualifies. An iteration of 29 does not.
- R3: An iteration with at most 8 taken branches, counting the closing branch, qualifies. An iteration with 9 does not.
- R4: A micro-op with uop_from_cache=0 in an iteration makes that iteration fail.
- R5: A micro-op with uop_call=1 or uop_ret=1 makes the iteration fail.
- R6: An iteration fails when its count of uop_push micro-ops differs from its count of uop_pop micro-ops. Equal counts pass.
- R7: A failing iteration resets the consecutive-pass count. Pass, fail, pass gives no replay; one further pass gives replay.
- R8: A taken backward branch whose target differs from the head records the new target as head and restarts the pass count.
- R9: mispredict ends replay in the next cycle and clears the head and the pass count, so two fresh qualifying iterations are needed again.
- R10: flush or thread_switch ends replay in the next cycle and clears all progress in the same way.
- R11: While replay is active, incoming micro-ops are ignored: replay stays high and the loop indices hold.
- R12: After reset, replay_sleep is 0 and both loop indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | 1 | A micro-op is written to the queue this cycle |
| uop_idx | input | 6 | Queue index of that micro-op |
| uop_target | input | 32 | Branch target address (used for taken backward branches) |
| uop_from_cache | input | 1 | Micro-op came from the decoded micro-op cache |
| uop_call | input | 1 | Micro-op is a call |
| uop_ret | input | 1 | Micro-op is a return |
| uop_push | input | 1 | Micro-op pushes onto the stack |
| uop_pop | input | 1 | Micro-op pops from the stack |
| uop_taken | input | 1 | Micro-op is a taken branch |
| uop_backward | input | 1 | Branch target lies behind the branch |
| mispredict | input | 1 | Branch misprediction |
| flush | input | 1 | Pipeline flush |
| thread_switch | input | 1 | Thread switch at the queue |
| replay_sleep | output | 1 | Replay loop from queue; front end sleeps |
| loop_start_idx | output | 6 | Queue index of the first micro-op of the loop |
| loop_end_idx | output | 6 | Queue index of the closing branch |

## Verification
The hardest state to reach is a limit landing exactly on its boundary in both of two back-to-back iterations while every other rule still holds. A single stray forward branch or an unbalanced push shifts which rule decides the outcome. The bench builds each iteration from a compact vector of size, taken-branch count and one violation kind. It places the forward branches first and the violation in the next slot, then feeds the same body twice after a fresh head branch. This lets each limit be hit at N and N+1 with nothing else in play.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    typedef struct packed {
        logic from_cache;
        logic call;
        logic ret;
        logic push;
        logic pop;
        logic taken;
        logic backward;
    } uop_flags_t;

endpackage

// File: rtl/lsd_body_check.sv
module lsd_body_check
    import lsd_pkg::*;
#(
    parameter int MAX_UOPS  = 28,
    parameter int MAX_TAKEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kill,
    input  logic       count_en,
    input  uop_flags_t flags,
    output logic       body_ok
);
    localparam int UW = $clog2(MAX_UOPS + 2);
    localparam int TW = $clog2(MAX_TAKEN + 2);
    localparam int BW = UW + 1;
    localparam logic [UW-1:0] U_MAX = UW'(MAX_UOPS);
    localparam logic [UW-1:0] U_SAT = UW'(MAX_UOPS + 1);
    localparam logic [TW-1:0] T_MAX = TW'(MAX_TAKEN);
    localparam logic [TW-1:0] T_SAT = TW'(MAX_TAKEN + 1);

    typedef struct packed {
        logic [UW-1:0] uops;
        logic [TW-1:0] taken;
        logic [BW-1:0] bal;
        logic          bad;
    } body_t;

    body_t s_q, s_d, incl;
    logic  boundary;

    always_comb begin
        // running totals including the micro-op presented this cycle
        incl.uops  = (s_q.uops == U_SAT) ? U_SAT : s_q.uops + UW'(1);
        incl.taken = s_q.taken;
        if (flags.taken && s_q.taken != T_SAT)
            incl.taken = s_q.taken + TW'(1);
        incl.bal = s_q.bal;
        if (flags.push) incl.bal = incl.bal + BW'(1);
        if (flags.pop)  incl.bal = incl.bal - BW'(1);
        incl.bad = s_q.bad | ~flags.from_cache | flags.call | flags.ret;

        body_ok  = (incl.uops <= U_MAX) && (incl.taken <= T_MAX)
                   && !incl.bad && (incl.bal == '0);
        boundary = flags.taken & flags.backward;

        s_d = s_q;
        if (kill)
            s_d = '0;
        else if (count_en)
            s_d = boundary ? '0 : incl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.uops <= U_SAT);

    a_r3_taken_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.taken <= T_SAT);

    a_r10_kill_clears_body: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (s_q == '0));

    a_r4_legacy_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !kill && !boundary && !flags.from_cache) |=> s_q.bad);

endmodule

// File: rtl/lsd_replay_ctrl.sv
module lsd_replay_ctrl #(
    parameter int QUEUE_DEPTH   = 56,
    parameter int ADDR_W        = 32,
    parameter int QUALIFY_ITERS = 2,
    localparam int IW = $clog2(QUEUE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              count_en,
    input  logic              taken,
    input  logic              backward,
    input  logic [ADDR_W-1:0] target,
    input  logic [IW-1:0]     idx,
    input  logic              body_ok,
    output logic              replay,
    output logic [IW-1:0]     start_idx,
    output logic [IW-1:0]     end_idx
);
    localparam int PW = $clog2(QUALIFY_ITERS + 1);
    localparam logic [PW-1:0] LAST_PASS = PW'(QUALIFY_ITERS - 1);
    localparam logic [IW-1:0] IDX_TOP   = IW'(QUEUE_DEPTH - 1);

    typedef struct packed {
        logic              head_valid;
        logic [ADDR_W-1:0] head;
        logic [PW-1:0]     passes;
        logic              replay;
        logic [IW-1:0]     start;
        logic [IW-1:0]     stop;
        logic [IW-1:0]     pend;
    } ctrl_t;

    ctrl_t q, d;
    logic back_taken, close;
    logic [IW-1:0] next_idx;

    always_comb begin
        back_taken = count_en & taken & backward;
        close      = back_taken & q.head_valid & (target == q.head);
        next_idx   = (idx == IDX_TOP) ? '0 : idx + IW'(1);

        d = q;
        if (kill) begin
            d = '0;
        end else if (close) begin
            d.pend = next_idx;
            if (body_ok) begin
                d.passes = q.passes + PW'(1);
                if (q.passes == LAST_PASS) begin
                    d.replay = 1'b1;
                    d.start  = q.pend;
                    d.stop   = idx;
                end
            end else begin
                d.passes = '0;
            end
        end else if (back_taken) begin
            d.head_valid = 1'b1;
            d.head       = target;
            d.passes     = '0;
            d.pend       = next_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign replay    = q.replay;
    assign start_idx = q.start;
    assign end_idx   = q.stop;

    a_r1_replay_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        q.replay |-> q.head_valid);

    a_r1_rise_on_backward: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.replay) |-> $past(count_en && taken && backward && body_ok));

    a_r11_replay_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.replay && !kill) |=> (q.replay && $stable(q.start) && $stable(q.stop)));

endmodule

// File: rtl/lsd_qualifier.sv
module lsd_qualifier
    import lsd_pkg::*;
#(
    parameter int QUEUE_DEPTH   = 56,
    parameter int ADDR_W        = 32,
    parameter int MAX_UOPS      = 28,
    parameter int MAX_TAKEN     = 8,
    parameter int QUALIFY_ITERS = 2,
    localparam int IW = $clog2(QUEUE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uop_valid,
    input  logic [IW-1:0]     uop_idx,
    input  logic [ADDR_W-1:0] uop_target,
    input  logic              uop_from_cache,
    input  logic              uop_call,
    input  logic              uop_ret,
    input  logic              uop_push,
    input  logic              uop_pop,
    input  logic              uop_taken,
    input  logic              uop_backward,
    input  logic              mispredict,
    input  logic              flush,
    input  logic              thread_switch,
    output logic              replay_sleep,
    output logic [IW-1:0]     loop_start_idx,
    output logic [IW-1:0]     loop_end_idx
);
    uop_flags_t flags;
    logic kill, count_en, body_ok;

    always_comb begin
        flags.from_cache = uop_from_cache;
        flags.call       = uop_call;
        flags.ret        = uop_ret;
        flags.push       = uop_push;
        flags.pop        = uop_pop;
        flags.taken      = uop_taken;
        flags.backward   = uop_backward;
        kill             = flush | mispredict | thread_switch;
        count_en         = uop_valid & ~replay_sleep;
    end

    lsd_body_check #(
        .MAX_UOPS (MAX_UOPS),
        .MAX_TAKEN(MAX_TAKEN)
    ) u_body (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill    (kill),
        .count_en(count_en),
        .flags   (flags),
        .body_ok (body_ok)
    );

    lsd_replay_ctrl #(
        .QUEUE_DEPTH  (QUEUE_DEPTH),
        .ADDR_W       (ADDR_W),
        .QUALIFY_ITERS(QUALIFY_ITERS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (kill),
        .count_en (count_en),
        .taken    (uop_taken),
        .backward (uop_backward),
        .target   (uop_target),
        .idx      (uop_idx),
        .body_ok  (body_ok),
        .replay   (replay_sleep),
        .start_idx(loop_start_idx),
        .end_idx  (loop_end_idx)
    );

    a_r9_mispredict_ends_replay: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> !replay_sleep);

    a_r10_flush_switch_end_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || thread_switch) |=> !replay_sleep);

endmodule

// File: tb/tb_lsd_qualifier.sv
module tb_lsd_qualifier;
    localparam int DEPTH = 56;
    localparam logic [31:0] HEAD_A = 32'h40;
    localparam logic [31:0] HEAD_B = 32'h80;
    localparam logic [31:0] HEAD_C = 32'hC0;

    // {size[13:8], taken[7:4], kind[3:1], expect[0]}
    // kind: 0 clean, 1 legacy uop, 2 call, 3 return, 4 lone push, 5 push+pop
    localparam int NV = 11;
    localparam logic [13:0] VECS [NV] = '{
        {6'd28, 4'd1, 3'd0, 1'b1},
        {6'd29, 4'd1, 3'd0, 1'b0},
        {6'd10, 4'd8, 3'd0, 1'b1},
        {6'd12, 4'd9, 3'd0, 1'b0},
        {6'd28, 4'd8, 3'd0, 1'b1},
        {6'd10, 4'd1, 3'd1, 1'b0},
        {6'd10, 4'd1, 3'd2, 1'b0},
        {6'd10, 4'd1, 3'd3, 1'b0},
        {6'd10, 4'd1, 3'd4, 1'b0},
        {6'd10, 4'd1, 3'd5, 1'b1},
        {6'd2,  4'd1, 3'd0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic uop_valid = 1'b0;
    logic [5:0] uop_idx = '0;
    logic [31:0] uop_target = '0;
    logic uop_from_cache = 1'b1, uop_call = 1'b0, uop_ret = 1'b0;
    logic uop_push = 1'b0, uop_pop = 1'b0, uop_taken = 1'b0, uop_backward = 1'b0;
    logic mispredict = 1'b0, flush = 1'b0, thread_switch = 1'b0;
    logic replay_sleep;
    logic [5:0] loop_start_idx, loop_end_idx;

    int tests = 0, fails = 0, qidx = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lsd_qualifier dut (
        .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_idx(uop_idx),
        .uop_target(uop_target), .uop_from_cache(uop_from_cache),
        .uop_call(uop_call), .uop_ret(uop_ret), .uop_push(uop_push),
        .uop_pop(uop_pop), .uop_taken(uop_taken), .uop_backward(uop_backward),
        .mispredict(mispredict), .flush(flush), .thread_switch(thread_switch),
        .replay_sleep(replay_sleep), .loop_start_idx(loop_start_idx),
        .loop_end_idx(loop_end_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic fc, input logic cl, input logic rt,
                        input logic pu, input logic po, input logic tk,
                        input logic bk, input logic [31:0] tgt);
        @(negedge clk);
        uop_valid = 1'b1; uop_idx = 6'(qidx); uop_target = tgt;
        uop_from_cache = fc; uop_call = cl; uop_ret = rt;
        uop_push = pu; uop_pop = po; uop_taken = tk; uop_backward = bk;
        qidx = (qidx + 1) % DEPTH;
    endtask

    task automatic idle();
        @(negedge clk);
        uop_valid = 1'b0; uop_from_cache = 1'b1; uop_call = 1'b0; uop_ret = 1'b0;
        uop_push = 1'b0; uop_pop = 1'b0; uop_taken = 1'b0; uop_backward = 1'b0;
    endtask

    task automatic head_br(input logic [31:0] tgt);
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, tgt);
    endtask

    // one iteration: forward taken branches first, then the violation slot, closing branch last
    task automatic body(input int n, input int t, input int kind, input logic [31:0] tgt,
                        output int first, output int last);
        first = qidx;
        for (int i = 0; i < n - 1; i++) begin
            if (i < t - 1)
                send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1000);
            else if (i == t - 1 && kind == 1)
                send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
            else if (i == t - 1 && kind == 2)
                send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
            else if (i == t - 1 && kind == 3)
                send(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
            else if (i == t - 1 && (kind == 4 || kind == 5))
                send(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
            else if (i == t && kind == 5)
                send(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
            else
                send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        end
        last = qidx;
        head_br(tgt);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        uop_valid = 1'b0;
        if (which == 0) flush = 1'b1;
        else if (which == 1) mispredict = 1'b1;
        else thread_switch = 1'b1;
        @(negedge clk);
        flush = 1'b0; mispredict = 1'b0; thread_switch = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int f, l, f2, l2, s0, e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 replay after reset", int'(replay_sleep), 0);
        chk("R12 start after reset", int'(loop_start_idx), 0);
        chk("R12 end after reset", int'(loop_end_idx), 0);

        // vector table: limits R2, R3, sources R4, calls/returns R5, balance R6
        for (int v = 0; v < NV; v++) begin
            int n, t, k, e;
            n = int'(VECS[v][13:8]);
            t = int'(VECS[v][7:4]);
            k = int'(VECS[v][3:1]);
            e = int'(VECS[v][0]);
            pulse(0);
            head_br(HEAD_A);
            body(n, t, k, HEAD_A, f, l);
            idle();
            chk($sformatf("R1 vec%0d one pass no replay", v), int'(replay_sleep), 0);
            body(n, t, k, HEAD_A, f2, l2);
            idle();
            chk($sformatf("R2/R3/R4/R5/R6 vec%0d decision", v), int'(replay_sleep), e);
            if (e == 1) begin
                chk($sformatf("R1 vec%0d start", v), int'(loop_start_idx), f2);
                chk($sformatf("R1 vec%0d end", v), int'(loop_end_idx), l2);
            end
        end

        // R7: a failing iteration resets the streak
        pulse(0);
        head_br(HEAD_A);
        body(10, 1, 0, HEAD_A, f, l);
        body(10, 1, 2, HEAD_A, f, l);
        body(10, 1, 0, HEAD_A, f, l);
        idle();
        chk("R7 pass-fail-pass no replay", int'(replay_sleep), 0);
        body(10, 1, 0, HEAD_A, f, l);
        idle();
        chk("R7 second consecutive pass", int'(replay_sleep), 1);

        // R8: new head restarts the count
        pulse(0);
        head_br(HEAD_A);
        body(6, 1, 0, HEAD_A, f, l);
        head_br(HEAD_B);
        body(6, 1, 0, HEAD_B, f, l);
        idle();
        chk("R8 restart after head change", int'(replay_sleep), 0);
        body(6, 1, 0, HEAD_B, f2, l2);
        idle();
        chk("R8 replay on new head", int'(replay_sleep), 1);
        chk("R8 start on new head", int'(loop_start_idx), f2);

        // R11: micro-ops ignored during replay
        s0 = int'(loop_start_idx);
        e0 = int'(loop_end_idx);
        send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        send(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        head_br(HEAD_C);
        idle();
        chk("R11 replay holds", int'(replay_sleep), 1);
        chk("R11 start holds", int'(loop_start_idx), s0);
        chk("R11 end holds", int'(loop_end_idx), e0);

        // R9: mispredict ends replay and clears progress
        pulse(1);
        chk("R9 mispredict drops replay", int'(replay_sleep), 0);
        head_br(HEAD_B);
        body(6, 1, 0, HEAD_B, f, l);
        idle();
        chk("R9 progress cleared", int'(replay_sleep), 0);
        body(6, 1, 0, HEAD_B, f, l);
        idle();
        chk("R9 requalifies", int'(replay_sleep), 1);

        // R10: flush and thread switch
        pulse(0);
        chk("R10 flush drops replay", int'(replay_sleep), 0);
        head_br(HEAD_A);
        body(5, 1, 0, HEAD_A, f, l);
        body(5, 1, 0, HEAD_A, f, l);
        idle();
        chk("R10 rebuilt replay", int'(replay_sleep), 1);
        pulse(2);
        chk("R10 thread switch drops replay", int'(replay_sleep), 0);
        body(5, 1, 0, HEAD_A, f, l);
        idle();
        chk("R10 head cleared by switch", int'(replay_sleep), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule